// File: doc/BRIEF.md
# Status Byte 2 Write Command Slave

This block is the command front end of a serial memory for a single write command. That command changes two configuration bits in the second status byte: a reset-enable flag and a sector-lockdown-enable flag. A host shifts an 8-bit opcode and one data byte into the block over SPI mode 0, most significant bit first, while chip select is low. A separate one-byte write-enable command arms a write-enable latch. The two flags can change only when that latch is set.

The block does not act while bits arrive. It evaluates the transaction on the deselect edge. At that point it commits the data or discards it, based on the latch, the byte alignment of the frame and a lockdown-frozen input. It always disarms the latch after a status-write opcode. The SPI pins are oversampled by a fast system clock, so all state lives in one clock domain. The flags are presented in parallel for the rest of the memory to use.

Top module: `stat2_wr_slave`

## Requirements
- R1: After reset the write-enable latch, the reset-enable flag and the lockdown-enable flag all read 0.
- R2: A frame of opcode 0x06 that ends on a multiple of 8 bits sets the write-enable latch. If the frame ends off a byte boundary, the latch is unchanged.
- R3: A frame of opcode 0x31 followed by a data byte, with the latch set and a byte-aligned deselect, loads the reset-enable flag from data bit 4 and the lockdown-enable flag from data bit 3. Data bits 7 to 5 and 2 to 0 have no effect.
- R4: With the write-enable latch clear, a 0x31 frame leaves both flags unchanged.
- R5: Neither flag changes while chip select is still low, even after the full data byte has been shifted in.
- R6: Bytes after the first data byte of a 0x31 frame have no effect on the flags.
- R7: While the lockdown-frozen input is high at deselect, the lockdown-enable flag keeps its value and the reset-enable flag is still updated.
- R8: A 0x31 frame that ends before the data byte is complete, or off a byte boundary, leaves both flags unchanged.
- R9: Every frame that delivers the full 0x31 opcode leaves the write-enable latch at 0, whether it commits or aborts.
- R10: A frame whose first byte is neither 0x06 nor 0x31 changes neither the latch nor the flags.
- R11: Bits are sampled on rising SCK only while chip select is low. SCK edges seen while deselected are discarded, and every selection starts with a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| sdi | input | 1 | SPI serial data in, MSB first |
| lock_frozen | input | 1 | High when the lockdown state is frozen; sampled at deselect |
| wel_o | output | 1 | Write-enable latch |
| rste_o | output | 1 | Reset-enable flag |
| sle_o | output | 1 | Sector-lockdown-enable flag |

## Verification
The write-enable latch is read and cleared on the same clock edge. A single deselect edge therefore gates the flag commit with the latch value and also drops the latch. The bench provokes this with a sweep of all 256 data bytes, each sent just after a write-enable frame. After every deselect it judges the new flag values and the cleared latch together against an arithmetic model. The frozen input also meets the commit in that edge, so the same sweep is repeated with it held high to confirm that only the reset-enable flag moves.

// File: rtl/stat2_pkg.sv
package stat2_pkg;
  localparam int          BYTE_W   = 8;
  localparam logic [7:0]  OP_WREN  = 8'h06;
  localparam logic [7:0]  OP_WRST2 = 8'h31;
  localparam int          RST_POS  = 4;
  localparam int          LCK_POS  = 3;

  typedef struct packed {
    logic [BYTE_W-1:0] opcode;
    logic              new_rst;
    logic              new_lck;
    logic [1:0]        bytes;
    logic              aligned;
  } frame_t;
endpackage

// File: rtl/stat2_sync.sv
module stat2_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic rst_n_s,
  output logic cs_hi,
  output logic cs_rise,
  output logic sck_rise,
  output logic sdi_s
);
  localparam int         NSIG    = 3;
  localparam logic [2:0] RST_VAL = 3'b100;

  logic [NSIG-1:0] din;
  logic [NSIG-1:0] dsync;
  logic [STAGES-1:0] rst_pipe;
  logic cs_prev_q, sck_prev_q;

  assign din = {cs_n, sck, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[STAGES-1];

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) chain_q <= {STAGES{RST_VAL[i]}};
      else          chain_q <= {chain_q[STAGES-2:0], din[i]};
    end
    assign dsync[i] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      cs_prev_q  <= dsync[2];
      sck_prev_q <= dsync[1];
    end
  end

  assign cs_hi    = dsync[2];
  assign cs_rise  = dsync[2] & ~cs_prev_q;
  assign sck_rise = dsync[1] & ~sck_prev_q & ~dsync[2];
  assign sdi_s    = dsync[0];
endmodule

// File: rtl/stat2_shift.sv
module stat2_shift
  import stat2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_hi,
  input  logic   sck_rise,
  input  logic   sdi_s,
  output frame_t frame
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] sh_q, sh_n;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [1:0]        bytes_q, bytes_n;
  logic [BYTE_W-1:0] op_q, op_n;
  logic [1:0]        dat_q, dat_n;
  logic [BYTE_W-1:0] full_byte;

  assign full_byte = {sh_q, sdi_s};

  always_comb begin
    sh_n    = sh_q;
    bit_n   = bit_q;
    bytes_n = bytes_q;
    op_n    = op_q;
    dat_n   = dat_q;
    if (cs_hi) begin
      sh_n    = '0;
      bit_n   = '0;
      bytes_n = '0;
      op_n    = '0;
      dat_n   = '0;
    end else if (sck_rise) begin
      sh_n  = full_byte[BYTE_W-2:0];
      bit_n = bit_q + 1'b1;
      if (bit_q == CNT_W'(BYTE_W-1)) begin
        if (bytes_q == 2'd0) op_n  = full_byte;
        if (bytes_q == 2'd1) dat_n = {full_byte[RST_POS], full_byte[LCK_POS]};
        if (bytes_q != 2'd3) bytes_n = bytes_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bit_q   <= '0;
      bytes_q <= '0;
      op_q    <= '0;
      dat_q   <= '0;
    end else begin
      sh_q    <= sh_n;
      bit_q   <= bit_n;
      bytes_q <= bytes_n;
      op_q    <= op_n;
      dat_q   <= dat_n;
    end
  end

  assign frame.opcode  = op_q;
  assign frame.new_rst = dat_q[1];
  assign frame.new_lck = dat_q[0];
  assign frame.bytes   = bytes_q;
  assign frame.aligned = (bit_q == '0);

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (bit_q == '0 && bytes_q == 2'd0));
endmodule

// File: rtl/stat2_status.sv
module stat2_status
  import stat2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_rise,
  input  logic   lock_frozen,
  input  frame_t frame,
  output logic   wel_o,
  output logic   rste_o,
  output logic   sle_o
);
  logic wel_q, wel_n;
  logic rst_q, rst_n_v;
  logic lck_q, lck_n;
  logic got_op, is_wren, is_wst2, full_ok;

  assign got_op  = cs_rise && (frame.bytes != 2'd0);
  assign is_wren = got_op && (frame.opcode == OP_WREN);
  assign is_wst2 = got_op && (frame.opcode == OP_WRST2);
  assign full_ok = frame.aligned && (frame.bytes >= 2'd2);

  always_comb begin
    wel_n   = wel_q;
    rst_n_v = rst_q;
    lck_n   = lck_q;
    if (is_wren && frame.aligned) wel_n = 1'b1;
    if (is_wst2) begin
      wel_n = 1'b0;
      if (full_ok && wel_q) begin
        rst_n_v = frame.new_rst;
        if (!lock_frozen) lck_n = frame.new_lck;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      rst_q <= 1'b0;
      lck_q <= 1'b0;
    end else begin
      wel_q <= wel_n;
      rst_q <= rst_n_v;
      lck_q <= lck_n;
    end
  end

  assign wel_o  = wel_q;
  assign rste_o = rst_q;
  assign sle_o  = lck_q;

  // R5
  no_early_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable({rst_q, lck_q}));
  // R4
  no_wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_q |=> $stable({rst_q, lck_q}));
  // R7
  frozen_lck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_frozen |=> $stable(lck_q));
  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame.bytes != 2'd0 && frame.opcode == OP_WRST2) |=> !wel_q);
  // R10
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame.bytes != 2'd0 && frame.opcode != OP_WRST2 && frame.opcode != OP_WREN)
    |=> $stable({wel_q, rst_q, lck_q}));
endmodule

// File: rtl/stat2_wr_slave.sv
module stat2_wr_slave
  import stat2_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  input  logic lock_frozen,
  output logic wel_o,
  output logic rste_o,
  output logic sle_o
);
  logic   rst_n_s, cs_hi, cs_rise, sck_rise, sdi_s;
  frame_t frame;

  stat2_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .rst_n_s(rst_n_s), .cs_hi(cs_hi), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sdi_s(sdi_s)
  );

  stat2_shift u_shift (
    .clk(clk), .rst_n(rst_n_s), .cs_hi(cs_hi), .sck_rise(sck_rise),
    .sdi_s(sdi_s), .frame(frame)
  );

  stat2_status u_status (
    .clk(clk), .rst_n(rst_n_s), .cs_rise(cs_rise), .lock_frozen(lock_frozen),
    .frame(frame), .wel_o(wel_o), .rste_o(rste_o), .sle_o(sle_o)
  );
endmodule

// File: tb/stat2_wr_slave_bench.sv
module stat2_wr_slave_bench;
  logic clk, rst_n, sck, cs_n, sdi, lock_frozen;
  logic wel_o, rste_o, sle_o;
  int checks = 0, errors = 0;
  logic ewel, erst, elck;

  stat2_wr_slave u_stat2_wr_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .lock_frozen(lock_frozen), .wel_o(wel_o), .rste_o(rste_o), .sle_o(sle_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s wel/rste/sle actual %b expected %b", tag, act, exp);
    end
  endtask

  // Sends n bits of v MSB first, then deselects and updates the model.
  task automatic frame(input logic [31:0] v, input int n, input logic frz,
                       input string tag, input bit midchk);
    logic [31:0] t;
    logic [7:0]  op, dat;
    lock_frozen = frz;
    cs_n = 1'b0;
    wait_clk(3);
    for (int i = 0; i < n; i++) begin
      sdi = v[n-1-i];
      sck = 1'b0;
      wait_clk(2);
      sck = 1'b1;
      wait_clk(2);
      sck = 1'b0;
    end
    wait_clk(4);
    if (midchk) check("R5", {wel_o, rste_o, sle_o}, {ewel, erst, elck});
    cs_n = 1'b1;
    wait_clk(8);
    if (n >= 8) begin
      t  = v >> (n - 8);
      op = t[7:0];
      if (op == 8'h06 && (n % 8) == 0) ewel = 1'b1;
      if (op == 8'h31) begin
        if ((n % 8) == 0 && n >= 16 && ewel) begin
          t   = v >> (n - 16);
          dat = t[7:0];
          erst = dat[4];
          if (!frz) elck = dat[3];
        end
        ewel = 1'b0;
      end
    end
    check(tag, {wel_o, rste_o, sle_o}, {ewel, erst, elck});
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; sdi = 1'b0; lock_frozen = 1'b0;
    ewel = 1'b0; erst = 1'b0; elck = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    check("R1", {wel_o, rste_o, sle_o}, 3'b000);

    // R11: SCK activity while deselected must be discarded
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; wait_clk(2); sck = 1'b0; wait_clk(2);
    end
    frame(32'h06, 8, 1'b0, "R11", 1'b0);
    // R10: unknown opcodes keep everything
    frame(32'h0518, 16, 1'b0, "R10", 1'b0);
    frame(32'hB1, 8, 1'b0, "R10", 1'b0);
    // R2: misaligned write-enable then aligned one
    frame(32'h0, 8, 1'b0, "R10", 1'b0);
    frame(32'h31FF, 16, 1'b0, "R3", 1'b0);
    frame(32'h18, 10, 1'b0, "R2", 1'b0);
    frame(32'h06, 8, 1'b0, "R2", 1'b0);

    // R3/R5/R9: full sweep of data bytes with write enable
    for (int d = 0; d < 256; d++) begin
      frame(32'h06, 8, 1'b0, "R2", 1'b0);
      frame({16'h0, 8'h31, 8'(d)}, 16, 1'b0, "R3", (d % 16) == 0);
    end
    // R7: same sweep with the lockdown frozen
    for (int d = 0; d < 256; d++) begin
      frame(32'h06, 8, 1'b0, "R2", 1'b0);
      frame({16'h0, 8'h31, 8'(d)}, 16, 1'b1, "R7", 1'b0);
    end
    // R4: no write enable
    for (int d = 0; d < 64; d++)
      frame({16'h0, 8'h31, 8'(d * 4 + 1)}, 16, 1'b0, "R4", 1'b0);
    // R6: trailing bytes ignored
    for (int d = 0; d < 16; d++) begin
      frame(32'h06, 8, 1'b0, "R2", 1'b0);
      frame({8'h31, 8'(d * 8), ~8'(d * 8), 8'hFF}, 32, 1'b0, "R6", 1'b0);
    end
    // R8/R9: aborted frames still clear the latch
    frame(32'h06, 8, 1'b0, "R2", 1'b0);
    frame(32'h31E, 12, 1'b0, "R8", 1'b0);
    frame(32'h06, 8, 1'b0, "R2", 1'b0);
    frame(32'h31, 8, 1'b0, "R9", 1'b0);
    frame(32'h06, 8, 1'b0, "R2", 1'b0);
    frame({7'h0, 8'h31, 8'h00, 1'b1}, 17, 1'b0, "R8", 1'b0);
    frame(32'h06, 8, 1'b0, "R2", 1'b0);
    frame(32'h0631, 16, 1'b0, "R2", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule